// File: doc/BRIEF.md
# Branch Target Buffer Predictor

A direct-mapped table that turns the current fetch address into the next fetch address. The fetch PC indexes the table every cycle. When the addressed entry is valid and its tag matches, the stored target becomes the predicted next PC. Otherwise the prediction is PC+1. The lookup is purely combinational, so the prediction belongs to the same cycle as the fetch address.

When a branch resolves further down the pipeline, the update port delivers four things: the branch PC, its target, whether it was taken, and the next PC that fetch predicted for it at the time. The block raises a mispredict flag in that same cycle. A policy input then decides whether the resolution writes the table, leaves it alone, or clears an entry. There are three policies: never predict taken, predict taken only for branches that jump to a lower address, and repeat the last outcome. Table entries are kept across policy changes.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so `pred_hit_o` is 0 and `pred_pc_o` equals `fetch_pc_i + 1` for any fetch address.
- R2: On a miss, `pred_hit_o` is 0 and `pred_pc_o` is `fetch_pc_i + 1` modulo 2^PC_W, so 0xFFFF wraps to 0x0000.
- R3: `mode_i` codes are 0 = never taken, 1 = backward only, 2 = last outcome, and 3 acts as 0. In code 0 or 3 the lookup never hits and no update changes the table, even when the update reports a taken branch.
- R4: In backward mode, an update writes a valid entry holding the branch's tag and target only if `upd_target_i < upd_pc_i` (unsigned). This holds whether the branch was taken or not. Forward targets and equal targets are never recorded.
- R5: In last-outcome mode, a taken update writes or refreshes the entry with the branch's tag and target.
- R6: In last-outcome mode, a not-taken update invalidates its entry only if that entry is valid and its tag matches. A not-taken branch that aliases to the same index with a different tag leaves the entry unchanged.
- R7: A hit requires a valid entry whose tag matches in backward or last-outcome mode. On a hit, `pred_hit_o` is 1 and `pred_pc_o` is the stored target.
- R8: Writes take effect at the rising clock edge. A lookup in the same cycle as a write to the same entry returns the old contents.
- R9: `mispredict_o` is 1 exactly when `upd_valid_i` is 1 and the resolved next PC differs from `upd_pred_pc_i`. The resolved next PC is `upd_target_i` if the branch was taken, otherwise `upd_pc_i + 1`. The flag is combinational in the update cycle.
- R10: The index is `pc[IDX_W-1:0]` and the tag is `pc[PC_W-1:IDX_W]`. Addresses that share an index but differ in tag do not hit each other's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Prediction policy select |
| fetch_pc_i | input | PC_W | Current fetch address |
| pred_pc_o | output | PC_W | Predicted next fetch address |
| pred_hit_o | output | 1 | Table hit for the fetch address |
| upd_valid_i | input | 1 | A branch resolution is presented |
| upd_pc_i | input | PC_W | Resolved branch address |
| upd_taken_i | input | 1 | Resolved direction |
| upd_target_i | input | PC_W | Branch target address |
| upd_pred_pc_i | input | PC_W | Next PC that was predicted for this branch |
| mispredict_o | output | 1 | Resolution differs from the prediction |

## Verification
`pred_pc_o`, `pred_hit_o` and `mispredict_o` are due in the same cycle as their inputs. The bench therefore drives each cycle's inputs on the falling edge and compares those outputs one time unit later. At that point the table still holds its contents from before the coming edge. An update changes lookups from the next cycle on. The bench's reference table is written only after the rising edge, so a lookup in the same cycle as a write is checked against the old contents. Directed cases cover aliasing, equal and forward targets, the wrap at the top address, and policy switches. They are followed by seeded random traffic over a narrow range of addresses so that hits and evictions occur often.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    MODE_NEVER = 2'd0,
    MODE_BWD   = 2'd1,
    MODE_LAST  = 2'd2,
    MODE_ALT   = 2'd3
  } btb_mode_e;
endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int PC_W  = 16,
  parameter int IDX_W = 3,
  localparam int TAG_W   = PC_W - IDX_W,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [PC_W-1:0]  rd_tgt_o,
  input  logic [IDX_W-1:0] pr_idx_i,
  output logic             pr_valid_o,
  output logic [TAG_W-1:0] pr_tag_o,
  input  logic             we_i,
  input  logic             wr_valid_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PC_W-1:0]  wr_tgt_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (we_i) valid_q[wr_idx_i] <= wr_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
      tgt_q[wr_idx_i] <= wr_tgt_i;
    end
  end

  // reads see pre-edge contents
  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_tgt_o   = tgt_q[rd_idx_i];
  assign pr_valid_o = valid_q[pr_idx_i];
  assign pr_tag_o   = tag_q[pr_idx_i];

  // R8: a written entry holds the written value from the next cycle on
  a_r8_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> valid_q[$past(wr_idx_i)] == $past(wr_valid_i));
endmodule

// File: rtl/btb_policy.sv
module btb_policy
  import btb_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  btb_mode_e        mode_i,
  input  logic             upd_valid_i,
  input  logic             upd_taken_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic [PC_W-1:0]  upd_target_i,
  input  logic             probe_hit_i,
  output logic             we_o,
  output logic             wr_valid_o
);
  logic backward;
  assign backward = upd_target_i < upd_pc_i;

  always_comb begin
    we_o       = 1'b0;
    wr_valid_o = 1'b1;
    if (upd_valid_i) begin
      unique case (mode_i)
        MODE_BWD:  we_o = backward;
        MODE_LAST: begin
          if (upd_taken_i) we_o = 1'b1;
          else if (probe_hit_i) begin
            we_o       = 1'b1;
            wr_valid_o = 1'b0;
          end
        end
        default:   we_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int IDX_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic [PC_W-1:0] pred_pc_o,
  output logic            pred_hit_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_target_i,
  input  logic [PC_W-1:0] upd_pred_pc_i,
  output logic            mispredict_o
);
  localparam int TAG_W = PC_W - IDX_W;

  btb_mode_e        mode;
  logic             rd_valid, pr_valid, we, wr_valid, probe_hit, lookup_en;
  logic [TAG_W-1:0] rd_tag, pr_tag;
  logic [PC_W-1:0]  rd_tgt, seq_pc, resolved_pc;

  assign mode = btb_mode_e'(mode_i);

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (fetch_pc_i[IDX_W-1:0]),
    .rd_valid_o (rd_valid),
    .rd_tag_o   (rd_tag),
    .rd_tgt_o   (rd_tgt),
    .pr_idx_i   (upd_pc_i[IDX_W-1:0]),
    .pr_valid_o (pr_valid),
    .pr_tag_o   (pr_tag),
    .we_i       (we),
    .wr_valid_i (wr_valid),
    .wr_idx_i   (upd_pc_i[IDX_W-1:0]),
    .wr_tag_i   (upd_pc_i[PC_W-1:IDX_W]),
    .wr_tgt_i   (upd_target_i)
  );

  assign probe_hit = pr_valid && (pr_tag == upd_pc_i[PC_W-1:IDX_W]);

  btb_policy #(.PC_W(PC_W)) u_policy (
    .mode_i       (mode),
    .upd_valid_i  (upd_valid_i),
    .upd_taken_i  (upd_taken_i),
    .upd_pc_i     (upd_pc_i),
    .upd_target_i (upd_target_i),
    .probe_hit_i  (probe_hit),
    .we_o         (we),
    .wr_valid_o   (wr_valid)
  );

  assign lookup_en  = (mode == MODE_BWD) || (mode == MODE_LAST);
  assign seq_pc     = fetch_pc_i + PC_W'(1);
  assign pred_hit_o = lookup_en && rd_valid && (rd_tag == fetch_pc_i[PC_W-1:IDX_W]);
  assign pred_pc_o  = pred_hit_o ? rd_tgt : seq_pc;

  assign resolved_pc  = upd_taken_i ? upd_target_i : upd_pc_i + PC_W'(1);
  assign mispredict_o = upd_valid_i && (resolved_pc != upd_pred_pc_i);

  // R3: disabled policy leaves the table untouched
  a_r3_never_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_NEVER || mode == MODE_ALT) |=> $stable(u_store.valid_q));
  // R4: backward policy only writes for lower targets
  a_r4_bwd_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_BWD && we) |-> (upd_target_i < upd_pc_i && wr_valid));
  // R5: taken resolution in last-outcome mode yields a valid matching entry
  a_r5_taken_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_LAST && upd_valid_i && upd_taken_i) |=>
      u_store.valid_q[$past(upd_pc_i[IDX_W-1:0])]);
  // R6: not-taken hit clears the entry
  a_r6_evict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_LAST && upd_valid_i && !upd_taken_i && probe_hit) |=>
      !u_store.valid_q[$past(upd_pc_i[IDX_W-1:0])]);
  // R2: a miss falls through to the sequential address
  a_r2_miss_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> pred_pc_o == fetch_pc_i + PC_W'(1));
  // R9: no mispredict without an update
  a_r9_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |-> !mispredict_o);
endmodule

// File: tb/test_btb_predictor.sv
`timescale 1ns/1ps
module test_btb_predictor;
  localparam int PC_W = 16;
  localparam int IDX_W = 3;
  localparam int ENT = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode;
  logic [PC_W-1:0] fetch_pc, upd_pc, upd_tgt, upd_pred;
  logic            upd_v, upd_tk;
  logic [PC_W-1:0] pred_pc;
  logic            pred_hit, mispred;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic            m_valid [ENT];
  logic [PC_W-1:0] m_pc    [ENT];
  logic [PC_W-1:0] m_tgt   [ENT];

  always #2.5 clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) i_btb_predictor (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .fetch_pc_i(fetch_pc),
    .pred_pc_o(pred_pc), .pred_hit_o(pred_hit), .upd_valid_i(upd_v),
    .upd_pc_i(upd_pc), .upd_taken_i(upd_tk), .upd_target_i(upd_tgt),
    .upd_pred_pc_i(upd_pred), .mispredict_o(mispred)
  );

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'(pc[IDX_W-1:0]);
  endfunction

  function automatic logic exp_hit(logic [1:0] md, logic [PC_W-1:0] pc);
    if (md != 2'd1 && md != 2'd2) return 1'b0;
    return m_valid[idx_of(pc)] && m_pc[idx_of(pc)][PC_W-1:IDX_W] == pc[PC_W-1:IDX_W];
  endfunction

  function automatic logic [PC_W-1:0] exp_pred(logic [1:0] md, logic [PC_W-1:0] pc);
    return exp_hit(md, pc) ? m_tgt[idx_of(pc)] : pc + 16'd1;
  endfunction

  task automatic check(string req, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare same-cycle outputs, model updates after posedge
  task automatic step(logic [1:0] md, logic [PC_W-1:0] fpc, logic uv,
                      logic [PC_W-1:0] upc, logic utk, logic [PC_W-1:0] utgt,
                      logic [PC_W-1:0] upred);
    logic h;
    logic [PC_W-1:0] resolved;
    logic hit_upd;
    @(negedge clk);
    mode = md; fetch_pc = fpc; upd_v = uv; upd_pc = upc; upd_tk = utk;
    upd_tgt = utgt; upd_pred = upred;
    #1;
    h = exp_hit(md, fpc);
    check(h ? "R7 hit target" : (md == 2'd1 || md == 2'd2) ? "R2 miss" : "R3 never-taken",
          pred_pc, exp_pred(md, fpc));
    check("R7/R10 hit flag", {15'd0, pred_hit}, {15'd0, h});
    resolved = utk ? utgt : upc + 16'd1;
    check("R9 mispredict", {15'd0, mispred}, {15'd0, uv && (resolved != upred)});
    @(posedge clk);
    #0.1;
    if (uv) begin
      hit_upd = m_valid[idx_of(upc)] && m_pc[idx_of(upc)][PC_W-1:IDX_W] == upc[PC_W-1:IDX_W];
      if (md == 2'd1 && utgt < upc) begin                // R4
        m_valid[idx_of(upc)] = 1'b1; m_pc[idx_of(upc)] = upc; m_tgt[idx_of(upc)] = utgt;
      end else if (md == 2'd2 && utk) begin              // R5
        m_valid[idx_of(upc)] = 1'b1; m_pc[idx_of(upc)] = upc; m_tgt[idx_of(upc)] = utgt;
      end else if (md == 2'd2 && !utk && hit_upd) begin  // R6
        m_valid[idx_of(upc)] = 1'b0;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < ENT; i++) begin
      m_valid[i] = 1'b0; m_pc[i] = '0; m_tgt[i] = '0;
    end
    mode = 2'd2; fetch_pc = '0; upd_v = 0; upd_pc = '0; upd_tk = 0;
    upd_tgt = '0; upd_pred = '0;
    repeat (3) @(posedge clk);
    // R1: reset state, every address misses
    #1;
    check("R1 reset pred", pred_pc, 16'h0001);
    check("R1 reset hit", {15'd0, pred_hit}, 16'd0);
    rst_n = 1'b1;
    step(2'd2, 16'h0010, 0, 0, 0, 0, 0);
    // R5/R8/R9: write and same-cycle lookup sees old (invalid) entry
    step(2'd2, 16'h0025, 1, 16'h0025, 1, 16'h0100, 16'h0026);
    step(2'd2, 16'h0025, 0, 0, 0, 0, 0);
    // R10: alias index 5, other tag
    step(2'd2, 16'h0045, 0, 0, 0, 0, 0);
    // R6: not-taken alias leaves entry; matching not-taken evicts
    step(2'd2, 16'h0025, 1, 16'h0045, 0, 16'h0300, 16'h0046);
    step(2'd2, 16'h0025, 1, 16'h0025, 0, 16'h0100, 16'h0100);
    step(2'd2, 16'h0025, 0, 0, 0, 0, 0);
    // R5 refresh
    step(2'd2, 16'h0025, 1, 16'h0025, 1, 16'h0200, 16'h0026);
    step(2'd2, 16'h0025, 1, 16'h0025, 1, 16'h0240, 16'h0200);
    step(2'd2, 16'h0025, 0, 0, 0, 0, 0);
    // R3: never-taken hides entries and ignores updates
    step(2'd0, 16'h0025, 1, 16'h0033, 1, 16'h0400, 16'h0034);
    step(2'd3, 16'h0033, 1, 16'h0034, 1, 16'h0010, 16'h0035);
    step(2'd2, 16'h0033, 0, 0, 0, 0, 0);
    step(2'd1, 16'h0034, 0, 0, 0, 0, 0);
    // R4: forward and equal targets skipped, backward not-taken recorded
    step(2'd1, 16'h0050, 1, 16'h0050, 1, 16'h0060, 16'h0051);
    step(2'd1, 16'h0050, 1, 16'h0071, 1, 16'h0071, 16'h0072);
    step(2'd1, 16'h0071, 1, 16'h0092, 0, 16'h0080, 16'h0093);
    step(2'd1, 16'h0092, 0, 0, 0, 0, 0);
    step(2'd2, 16'h0092, 0, 0, 0, 0, 0);
    // R2: wrap
    step(2'd2, 16'hFFFF, 0, 0, 0, 0, 0);
    // random traffic over a narrow address window
    void'($urandom(32'd470));
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] a, b, t, p;
      logic [1:0] md;
      a = 16'(($urandom % 4) << IDX_W) | 16'($urandom % ENT);
      b = 16'(($urandom % 4) << IDX_W) | 16'($urandom % ENT);
      t = 16'($urandom % 64);
      md = ($urandom % 8 == 0) ? 2'($urandom % 4) : (($urandom % 2) ? 2'd2 : 2'd1);
      p = ($urandom % 2) ? exp_pred(md, b) : 16'($urandom % 64);
      step(md, a, 1'($urandom % 2), b, 1'($urandom % 2), t, p);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule